// File: doc/BRIEF.md
# Word-to-Byte Card Data FIFO Engine

This block sits between a register front end that moves 32-bit words and a card-side link that carries one byte per handshake. It holds a 16-entry word FIFO. In the receive direction it packs incoming card bytes into words, least significant byte first, and pushes each word into the FIFO. The front end then pops those words. In the transmit direction the front end pushes words, and the engine pops each one and sends its bytes to the card, least significant byte first.

A transfer starts with a one-cycle start pulse that carries a direction and a byte length. A remaining-byte counter drops by one for every byte moved, and no more than one byte moves per clock. When the counter reaches zero, the engine flushes any partial receive word and drops any unsent transmit bytes. It then raises its end-of-transfer flags. The enable turns itself off once the counter is zero and the FIFO has drained.

The block reports FIFO occupancy through two flag groups. The direction in use picks which group is driven, and the other group reads as all zeros.

Top module: `card_byte_fifo_engine`

## Requirements
- R1: The FIFO keeps 16 words of 32 bits in arrival order. When no receive transfer is enabled, a bus push stores a word if the FIFO is not full. When no transmit transfer is enabled, a bus pop returns the oldest word on `bus_rdata` one cycle later if the FIFO is not empty. A push to a full FIFO or a pop from an empty FIFO changes nothing, gives a one-cycle `bus_err` pulse, and a rejected pop loads zero into `bus_rdata`.
- R2: A `cfg_start` pulse loads `byte_cnt` from `cfg_len`, latches `cfg_dir_rx` (1 = card to controller, 0 = controller to card), sets `xfer_en` and clears both end flags. All of this is visible the next cycle.
- R3: When receiving, the first accepted card byte of a word lands in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24. The word is pushed on the clock of the fourth byte.
- R4: When the byte that brings `byte_cnt` to zero completes a word only partly, that word is pushed on the same clock with its unfilled upper bytes zero.
- R5: `card_rx_ready` is high only when a receive transfer is enabled, `byte_cnt` is not zero and the FIFO holds fewer than 16 words. A byte is taken only on a clock where `card_rx_valid` and `card_rx_ready` are both high.
- R6: When transmitting, the engine pops a word and sends its bytes on `card_tx_data` least significant byte first. It holds `card_tx_valid` and the byte steady until `card_tx_ready` is seen.
- R7: A transmit stops when `byte_cnt` reaches zero. Bytes still unsent from the current word are dropped, and no further word is popped.
- R8: `byte_cnt` falls by exactly one on each clock that moves a card byte, and otherwise holds while enabled.
- R9: `xfer_done` and `block_done` both become set on the clock at which an enabled transfer's count is or becomes zero. They stay set until the next start.
- R10: `xfer_en` clears by itself one cycle after a cycle in which it was set, `byte_cnt` was zero and the FIFO was empty.
- R11: Flag decode from the FIFO word count n:
  - empty when n = 0;
  - data-available when n ≠ 0;
  - full when n = 16;
  - transmit half-empty when n ≤ 8;
  - receive half-full when n ≥ 8;
  - active equals `xfer_en`.
- R12: When the latched direction is 1, only the `rx_*` flags may be high and all `tx_*` flags are zero. When it is 0, the reverse holds. After reset the direction is 0.
- R13: While a receive is enabled, any bus push is rejected with a `bus_err` pulse. While a transmit is enabled, any bus pop is rejected with a `bus_err` pulse and `bus_rdata` set to zero. In both cases the FIFO is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | One-cycle pulse that starts a transfer |
| cfg_dir_rx | input | 1 | Direction for the start: 1 = card to controller |
| cfg_len | input | 16 | Byte length loaded at start |
| xfer_en | output | 1 | Transfer enabled |
| byte_cnt | output | 16 | Remaining byte count |
| xfer_done | output | 1 | Data end flag |
| block_done | output | 1 | Block end flag |
| bus_push | input | 1 | Word push request from the front end |
| bus_wdata | input | 32 | Word to push |
| bus_pop | input | 1 | Word pop request from the front end |
| bus_rdata | output | 32 | Popped word, valid the cycle after a pop |
| bus_err | output | 1 | One-cycle pulse for a rejected push or pop |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | Engine accepts a card byte |
| card_tx_valid | output | 1 | Engine offers a byte to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card accepts the byte |
| tx_active | output | 1 | Transmit group: transfer active |
| tx_half_empty | output | 1 | Transmit group: at most half full |
| tx_full | output | 1 | Transmit group: FIFO full |
| tx_empty | output | 1 | Transmit group: FIFO empty |
| tx_avail | output | 1 | Transmit group: data present |
| rx_active | output | 1 | Receive group: transfer active |
| rx_half_full | output | 1 | Receive group: at least half full |
| rx_full | output | 1 | Receive group: FIFO full |
| rx_empty | output | 1 | Receive group: FIFO empty |
| rx_avail | output | 1 | Receive group: data present |

## Verification
Some properties can be checked on every cycle, and the assertions cover these:
- the FIFO count stays in range;
- a full FIFO keeps `card_rx_ready` low and a push to it raises `bus_err`;
- the transmit byte and its valid stay steady while the card stalls;
- the byte counter steps down by one per handshake and holds otherwise;
- the end flags rise and the enable falls when their conditions hold;
- the two flag groups are never high together.

Other behaviour only the bench scenarios can show. This covers the little-endian packing and zero-padding of a short final word, the exact byte order sent to the card, and the dropping of leftover transmit bytes. It also covers the refill of a full FIFO as words are popped, and the rejection of bus accesses to the side the engine owns. The bench compares every output against its behavioural model on each clock and adds direct value checks for these cases.

// File: rtl/cbf_pkg.sv
`timescale 1ns/1ps
package cbf_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic active;
    logic half;
    logic full;
    logic empty;
    logic avail;
  } grp_flags_t;

  function automatic int lane_bits(input int lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction
endpackage

// File: rtl/cbf_word_fifo.sv
`timescale 1ns/1ps
module cbf_word_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [DW-1:0]    wdata,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] fill,
  output logic             full,
  output logic             empty
);
  localparam logic [CNT_W-1:0] FULL_V = CNT_W'(DEPTH);

  logic [DW-1:0]    store [DEPTH];
  logic [PTR_W-1:0] rd_pos;
  logic [PTR_W-1:0] wr_pos;
  logic             do_push;
  logic             do_pop;

  assign full    = (fill == FULL_V);
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  // DEPTH is a power of two, so truncation gives the modulo wrap
  assign wr_pos  = rd_pos + fill[PTR_W-1:0];
  assign head    = store[rd_pos];

  always_ff @(posedge clk) begin
    if (do_push) store[wr_pos] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pos <= '0;
      fill   <= '0;
    end else begin
      if (do_pop) rd_pos <= rd_pos + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/cbf_rx_packer.sv
`timescale 1ns/1ps
module cbf_rx_packer #(
  parameter int DW = 32,
  localparam int BPW = DW / cbf_pkg::BYTE_W,
  localparam int LW  = cbf_pkg::lane_bits(BPW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          byte_ok,
  input  logic [7:0]    byte_in,
  input  logic          last,
  output logic          word_valid,
  output logic [DW-1:0] word_out
);
  logic [DW-1:0] acc_q;
  logic [LW-1:0] lane_q;

  assign word_valid = byte_ok && ((lane_q == LW'(BPW - 1)) || last);

  for (genvar i = 0; i < BPW; i++) begin : g_lane
    assign word_out[8*i +: 8] = (lane_q == LW'(i)) ? byte_in : acc_q[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (word_valid) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (byte_ok) begin
      acc_q[8*lane_q +: 8] <= byte_in;
      lane_q               <= lane_q + 1'b1;
    end
  end
endmodule

// File: rtl/cbf_tx_unpacker.sv
`timescale 1ns/1ps
module cbf_tx_unpacker #(
  parameter int DW = 32,
  localparam int BPW = DW / cbf_pkg::BYTE_W,
  localparam int KW  = $clog2(BPW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic          take,
  input  logic          last,
  output logic          have,
  output logic [7:0]    byte_out
);
  logic [DW-1:0] shift_q;
  logic [KW-1:0] left_q;

  assign have     = (left_q != '0);
  assign byte_out = shift_q[7:0];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      shift_q <= '0;
      left_q  <= '0;
    end else if (load) begin
      shift_q <= load_word;
      left_q  <= KW'(BPW);
    end else if (take) begin
      if (last) begin
        left_q <= '0;
      end else begin
        shift_q <= shift_q >> 8;
        left_q  <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbf_flag_decode.sv
`timescale 1ns/1ps
module cbf_flag_decode #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             [CNT_W-1:0] fill,
  input  logic                         dir_rx,
  input  logic                         enabled,
  output cbf_pkg::grp_flags_t          tx_grp,
  output cbf_pkg::grp_flags_t          rx_grp
);
  localparam logic [CNT_W-1:0] FULL_V = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_V = CNT_W'(DEPTH / 2);

  cbf_pkg::grp_flags_t tx_raw;
  cbf_pkg::grp_flags_t rx_raw;

  always_comb begin
    tx_raw.active = enabled;
    tx_raw.half   = (fill <= HALF_V);
    tx_raw.full   = (fill == FULL_V);
    tx_raw.empty  = (fill == '0);
    tx_raw.avail  = (fill != '0);
    rx_raw        = tx_raw;
    rx_raw.half   = (fill >= HALF_V);
  end

  assign tx_grp = dir_rx ? '0 : tx_raw;
  assign rx_grp = dir_rx ? rx_raw : '0;
endmodule

// File: rtl/card_byte_fifo_engine.sv
`timescale 1ns/1ps
module card_byte_fifo_engine #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_start,
  input  logic             cfg_dir_rx,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             xfer_en,
  output logic [LEN_W-1:0] byte_cnt,
  output logic             xfer_done,
  output logic             block_done,
  input  logic             bus_push,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_pop,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_err,
  input  logic             card_rx_valid,
  input  logic [7:0]       card_rx_data,
  output logic             card_rx_ready,
  output logic             card_tx_valid,
  output logic [7:0]       card_tx_data,
  input  logic             card_tx_ready,
  output logic             tx_active,
  output logic             tx_half_empty,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             tx_avail,
  output logic             rx_active,
  output logic             rx_half_full,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             rx_avail
);
  logic             en_q, dir_q, done_q;
  logic [LEN_W-1:0] cnt_q, cnt_nxt;
  logic             eng_rx, eng_tx, cnt_nz, last_byte;
  logic             rx_take, tx_take, tx_load, moved;
  logic             bus_push_ok, bus_pop_ok;
  logic             fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [DW-1:0]    fifo_wdata, fifo_head;
  logic [CNT_W-1:0] fill_cnt;
  logic             pk_valid;
  logic [DW-1:0]    pk_word;
  logic             up_have;
  logic [7:0]       up_byte;
  logic             err_q;
  logic [DW-1:0]    rdata_q;
  cbf_pkg::grp_flags_t tx_grp, rx_grp;

  assign eng_rx    = en_q && dir_q;
  assign eng_tx    = en_q && !dir_q;
  assign cnt_nz    = (cnt_q != '0);
  assign last_byte = (cnt_q == LEN_W'(1));

  assign card_rx_ready = eng_rx && cnt_nz && !fifo_full;
  assign rx_take       = card_rx_ready && card_rx_valid;
  assign card_tx_valid = eng_tx && cnt_nz && up_have;
  assign card_tx_data  = up_byte;
  assign tx_take       = card_tx_valid && card_tx_ready;
  assign tx_load       = eng_tx && cnt_nz && !up_have && !fifo_empty;
  assign moved         = rx_take || tx_take;
  assign cnt_nxt       = moved ? cnt_q - 1'b1 : cnt_q;

  // the engine owns the FIFO write side while receiving, the read side while transmitting
  assign bus_push_ok = bus_push && !eng_rx && !fifo_full;
  assign bus_pop_ok  = bus_pop && !eng_tx && !fifo_empty;
  assign fifo_push   = eng_rx ? pk_valid : bus_push;
  assign fifo_wdata  = eng_rx ? pk_word  : bus_wdata;
  assign fifo_pop    = eng_tx ? tx_load  : bus_pop;

  cbf_word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (fifo_push),
    .wdata (fifo_wdata),
    .pop   (fifo_pop),
    .head  (fifo_head),
    .fill  (fill_cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  cbf_rx_packer #(.DW(DW)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .clear      (cfg_start),
    .byte_ok    (rx_take),
    .byte_in    (card_rx_data),
    .last       (last_byte),
    .word_valid (pk_valid),
    .word_out   (pk_word)
  );

  cbf_tx_unpacker #(.DW(DW)) u_unpack (
    .clk       (clk),
    .rst       (rst),
    .clear     (cfg_start),
    .load      (tx_load),
    .load_word (fifo_head),
    .take      (tx_take),
    .last      (last_byte),
    .have      (up_have),
    .byte_out  (up_byte)
  );

  cbf_flag_decode #(.DEPTH(DEPTH)) u_flags (
    .fill    (fill_cnt),
    .dir_rx  (dir_q),
    .enabled (en_q),
    .tx_grp  (tx_grp),
    .rx_grp  (rx_grp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cfg_start) begin
      en_q   <= 1'b1;
      dir_q  <= cfg_dir_rx;
      cnt_q  <= cfg_len;
      done_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (en_q && !cnt_nz && fifo_empty) en_q <= 1'b0;
      if (en_q && (cnt_nxt == '0)) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      err_q <= (bus_push && !bus_push_ok) || (bus_pop && !bus_pop_ok);
      if (bus_pop) rdata_q <= bus_pop_ok ? fifo_head : '0;
    end
  end

  assign xfer_en       = en_q;
  assign byte_cnt      = cnt_q;
  assign xfer_done     = done_q;
  assign block_done    = done_q;
  assign bus_err       = err_q;
  assign bus_rdata     = rdata_q;
  assign tx_active     = tx_grp.active;
  assign tx_half_empty = tx_grp.half;
  assign tx_full       = tx_grp.full;
  assign tx_empty      = tx_grp.empty;
  assign tx_avail      = tx_grp.avail;
  assign rx_active     = rx_grp.active;
  assign rx_half_full  = rx_grp.half;
  assign rx_full       = rx_grp.full;
  assign rx_empty      = rx_grp.empty;
  assign rx_avail      = rx_grp.avail;
endmodule

// File: rtl/cbf_checker.sv
`timescale 1ns/1ps
module cbf_checker #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_start,
  input logic             xfer_en,
  input logic [LEN_W-1:0] byte_cnt,
  input logic             xfer_done,
  input logic             bus_push,
  input logic             bus_err,
  input logic             card_rx_valid,
  input logic             card_rx_ready,
  input logic             card_tx_valid,
  input logic             card_tx_ready,
  input logic [7:0]       card_tx_data,
  input logic [CNT_W-1:0] fill_cnt,
  input logic             tx_any,
  input logic             rx_any
);
  logic moves;
  assign moves = (card_rx_valid && card_rx_ready) || (card_tx_valid && card_tx_ready);

  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CNT_W'(DEPTH));

  assert_push_full_err_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_push && fill_cnt == CNT_W'(DEPTH)) |=> bus_err);

  assert_rx_hold_full_R5: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt == CNT_W'(DEPTH)) |-> !card_rx_ready);

  assert_tx_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (card_tx_valid && !card_tx_ready && !cfg_start) |=> (card_tx_valid && $stable(card_tx_data)));

  assert_cnt_step_R8: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && moves && !cfg_start) |=> (byte_cnt == $past(byte_cnt) - LEN_W'(1)));

  assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && !moves && !cfg_start) |=> $stable(byte_cnt));

  assert_done_set_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && byte_cnt == '0 && !cfg_start) |=> xfer_done);

  assert_autoclear_R10: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && byte_cnt == '0 && fill_cnt == '0 && !cfg_start) |=> !xfer_en);

  assert_one_group_R12: assert property (@(posedge clk) disable iff (rst)
    !(tx_any && rx_any));
endmodule

bind card_byte_fifo_engine cbf_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_cbf_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_start     (cfg_start),
  .xfer_en       (xfer_en),
  .byte_cnt      (byte_cnt),
  .xfer_done     (xfer_done),
  .bus_push      (bus_push),
  .bus_err       (bus_err),
  .card_rx_valid (card_rx_valid),
  .card_rx_ready (card_rx_ready),
  .card_tx_valid (card_tx_valid),
  .card_tx_ready (card_tx_ready),
  .card_tx_data  (card_tx_data),
  .fill_cnt      (fill_cnt),
  .tx_any        (tx_active | tx_half_empty | tx_full | tx_empty | tx_avail),
  .rx_any        (rx_active | rx_half_full | rx_full | rx_empty | rx_avail)
);

// File: tb/card_byte_fifo_engine_test.sv
`timescale 1ns/1ps
module card_byte_fifo_engine_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_start = 1'b0, cfg_dir_rx = 1'b0;
  logic [15:0] cfg_len = '0;
  logic bus_push = 1'b0, bus_pop = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic card_rx_valid = 1'b0, card_tx_ready = 1'b0;
  logic [7:0] card_rx_data = '0;
  logic xfer_en, xfer_done, block_done, bus_err, card_rx_ready, card_tx_valid;
  logic [15:0] byte_cnt;
  logic [31:0] bus_rdata;
  logic [7:0] card_tx_data;
  logic tx_active, tx_half_empty, tx_full, tx_empty, tx_avail;
  logic rx_active, rx_half_full, rx_full, rx_empty, rx_avail;

  card_byte_fifo_engine uut (.*);

  always #4 clk = ~clk;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit checking = 0, done_flag = 0;

  // behavioural reference state
  logic [31:0] m_q[$];
  logic [7:0]  rx_bytes[$];
  logic [7:0]  tx_log[$];
  int  rx_idx = 0, m_cnt = 0, m_k = 0, m_tk = 0;
  bit  m_en = 0, m_dir = 0, m_done = 0, m_err = 0;
  logic [31:0] m_acc = '0, m_sh = '0, m_rdata = '0;
  bit  rx_on = 0;
  int  rx_pat = 0, tx_pat = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    bit erx, etx, full, empty, rxr, txv, rx_t, tx_t, ld, bpu, bpo, en_o;
    logic [31:0] head;
    int cn;
    if (rst) begin
      m_q.delete(); m_cnt = 0; m_k = 0; m_tk = 0; m_en = 0; m_dir = 0;
      m_done = 0; m_err = 0; m_acc = 0; m_sh = 0; m_rdata = 0;
    end else begin
      en_o  = m_en;
      erx   = m_en && m_dir;
      etx   = m_en && !m_dir;
      full  = (m_q.size() == 16);
      empty = (m_q.size() == 0);
      rxr   = erx && m_cnt != 0 && !full;
      txv   = etx && m_cnt != 0 && m_tk != 0;
      rx_t  = rxr && card_rx_valid;
      tx_t  = txv && card_tx_ready;
      ld    = etx && m_cnt != 0 && m_tk == 0 && !empty;
      bpu   = bus_push && !erx && !full;
      bpo   = bus_pop && !etx && !empty;
      m_err = (bus_push && !bpu) || (bus_pop && !bpo);
      head  = empty ? 32'h0 : m_q[0];
      if (bpo || ld) void'(m_q.pop_front());
      if (bus_pop) m_rdata = bpo ? head : 32'h0;
      if (tx_t) begin
        tx_log.push_back(m_sh[7:0]);
        if (m_cnt == 1) m_tk = 0;
        else begin m_sh = m_sh >> 8; m_tk--; end
      end
      if (ld) begin m_sh = head; m_tk = 4; end
      if (bpu) m_q.push_back(bus_wdata);
      if (rx_t) begin
        m_acc[8*m_k +: 8] = card_rx_data;
        rx_idx++;
        if (m_k == 3 || m_cnt == 1) begin m_q.push_back(m_acc); m_acc = 0; m_k = 0; end
        else m_k++;
      end
      cn = (rx_t || tx_t) ? m_cnt - 1 : m_cnt;
      if (cfg_start) begin
        m_en = 1; m_dir = cfg_dir_rx; m_cnt = int'(cfg_len); m_done = 0;
        m_acc = 0; m_k = 0; m_tk = 0; rx_idx = 0; tx_log.delete();
      end else begin
        if (m_en && m_cnt == 0 && empty) m_en = 0;
        if (en_o && cn == 0) m_done = 1;
        m_cnt = cn;
      end
    end
  end

  // card-side stimulus
  always @(negedge clk) begin
    cyc++;
    card_rx_valid = rx_on && (rx_idx < rx_bytes.size()) && (rx_pat == 0 || (cyc % 3) != 1);
    card_rx_data  = (rx_idx < rx_bytes.size()) ? rx_bytes[rx_idx] : 8'h00;
    card_tx_ready = (tx_pat == 0) ? 1'b1 : ((cyc % 4) != 2);
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int n;
    bit tv;
    if (checking && !rst) begin
      n  = m_q.size();
      tv = m_en && !m_dir && m_cnt != 0 && m_tk != 0;
      chk("R1 R13 bus_err", bus_err, m_err);
      chk("R1 bus_rdata", bus_rdata, m_rdata);
      chk("R10 xfer_en", xfer_en, m_en);
      chk("R8 byte_cnt", byte_cnt, m_cnt);
      chk("R9 xfer_done", xfer_done, m_done);
      chk("R9 block_done", block_done, m_done);
      chk("R5 card_rx_ready", card_rx_ready, m_en && m_dir && m_cnt != 0 && n < 16);
      chk("R6 card_tx_valid", card_tx_valid, tv);
      if (tv) chk("R6 card_tx_data", card_tx_data, m_sh[7:0]);
      chk("R11 R12 tx flags", {tx_active, tx_half_empty, tx_full, tx_empty, tx_avail},
          m_dir ? 5'b0 : {m_en, n <= 8, n == 16, n == 0, n != 0});
      chk("R11 R12 rx flags", {rx_active, rx_half_full, rx_full, rx_empty, rx_avail},
          !m_dir ? 5'b0 : {m_en, n >= 8, n == 16, n == 0, n != 0});
    end
  end

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push_w(input logic [31:0] w);
    @(negedge clk); bus_push = 1'b1; bus_wdata = w;
    @(negedge clk); bus_push = 1'b0;
  endtask

  task automatic pop_w(output logic [31:0] w, output logic e);
    @(negedge clk); bus_pop = 1'b1;
    @(negedge clk); bus_pop = 1'b0; w = bus_rdata; e = bus_err;
  endtask

  task automatic start_xfer(input logic dir, input int len);
    @(negedge clk); cfg_start = 1'b1; cfg_dir_rx = dir; cfg_len = 16'(len);
    @(negedge clk); cfg_start = 1'b0;
  endtask

  initial begin
    #1600000;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic e;
    wait_clk(3);
    rst = 1'b0;
    checking = 1;
    @(negedge clk);
    chk("R12 reset tx_empty", tx_empty, 1);
    chk("R11 reset tx_half_empty", tx_half_empty, 1);
    chk("R10 reset xfer_en", xfer_en, 0);

    // idle bus access: fill, overflow, drain, underflow
    for (int i = 0; i < 17; i++) begin
      push_w(32'hA500_0000 + 32'(i));
      if (i == 7) chk("R11 half-empty at 8", tx_half_empty, 1);
      if (i == 8) chk("R11 half-empty at 9", tx_half_empty, 0);
    end
    chk("R1 push to full err", bus_err, 1);
    chk("R11 full", tx_full, 1);
    for (int i = 0; i < 17; i++) begin
      pop_w(w, e);
      if (i < 16) chk("R1 pop order", w, 32'hA500_0000 + 32'(i));
      else begin chk("R1 empty pop data", w, 0); chk("R1 empty pop err", e, 1); end
    end

    // receive, 10 bytes
    rx_bytes.delete();
    for (int i = 1; i <= 10; i++) rx_bytes.push_back(8'(i));
    start_xfer(1'b1, 10);
    chk("R2 start en", xfer_en, 1);
    chk("R2 start len", byte_cnt, 10);
    rx_on = 1;
    push_w(32'hDEAD_BEEF);
    chk("R13 push during rx", bus_err, 1);
    wait_clk(20);
    chk("R12 tx group silent in rx", tx_empty, 0);
    chk("R9 rx done", xfer_done, 1);
    pop_w(w, e); chk("R3 first word", w, 32'h0403_0201);
    pop_w(w, e); chk("R3 second word", w, 32'h0807_0605);
    pop_w(w, e); chk("R4 partial word", w, 32'h0000_0A09);
    wait_clk(2);
    chk("R10 rx enable cleared", xfer_en, 0);

    // receive with gaps that overruns the FIFO
    rx_on = 0; rx_pat = 1;
    rx_bytes.delete();
    for (int i = 0; i < 72; i++) rx_bytes.push_back(8'((i * 7 + 3) & 8'hFF));
    start_xfer(1'b1, 72);
    rx_on = 1;
    wait_clk(150);
    chk("R5 ready low when full", card_rx_ready, 0);
    chk("R11 rx full", rx_full, 1);
    for (int j = 0; j < 18; j++) begin
      pop_w(w, e);
      chk("R3 refill word", w, {rx_bytes[4*j+3], rx_bytes[4*j+2], rx_bytes[4*j+1], rx_bytes[4*j]});
      wait_clk(4);
    end
    wait_clk(4);
    chk("R10 long rx cleared", xfer_en, 0);
    rx_on = 0;

    // transmit 9 bytes from 3 words under a stalling card
    push_w(32'h4433_2211);
    push_w(32'h8877_6655);
    push_w(32'hCCBB_AA99);
    tx_pat = 1;
    start_xfer(1'b0, 9);
    pop_w(w, e);
    chk("R13 pop during tx err", e, 1);
    chk("R13 pop during tx data", w, 0);
    wait_clk(60);
    chk("R7 tx byte count", tx_log.size(), 9);
    for (int i = 0; i < 9; i++)
      if (i < tx_log.size()) chk("R6 tx byte order", tx_log[i], 8'(8'h11 * (i + 1)));
    chk("R7 tx count zero", byte_cnt, 0);
    chk("R10 tx enable cleared", xfer_en, 0);
    chk("R9 tx done", block_done, 1);

    // zero length start
    start_xfer(1'b0, 0);
    wait_clk(3);
    chk("R9 zero length done", xfer_done, 1);
    chk("R10 zero length cleared", xfer_en, 0);

    wait_clk(2);
    checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule